// File: doc/BRIEF.md
# Standard-Mode Printer Port Register Front-End

This block sits behind a byte-wide host register bus and presents the three registers of a standard-mode printer port: an output data latch, a printer status byte and a control byte. The control byte drives the strobe, init, select and auto-linefeed lines directly. Each time software raises strobe with a printer selected, the latched data byte is handed to a downstream byte sink as a one-cycle pulse. When the interrupt enable is on, the strobe also queues an interrupt.

There is no real printer attached, so the printer's side of the acknowledge/busy handshake is modelled inside the block. Software polls the status register, and each qualifying poll moves the modelled handshake one step. The step that completes the handshake also retires the queued interrupt. When the direction bit selects input, a data register read returns an externally supplied input byte.

For memory-mapped placement the bus address is right-shifted by a parameter before it is decoded. Only byte accesses are used. No parallel-port cycle types beyond standard mode are handled.

Top module: `printer_port_regs`

## Requirements
- R1: After reset the status register reads 0xD9, the control register reads 0x0C, the data latch reads 0x00, `irq` is 0 and `sink_valid` is 0. Status bit positions are: 7 not-busy, 6 ack, 5 paper-out, 4 online, 3 no-error, 0 timeout. Control bit positions are: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init, 1 auto-linefeed, 0 strobe.
- R2: The register offset is `bus_addr >> ADDR_SHIFT`. Offset 0 is data, 1 is status and 2 is control. A read of any other offset returns 0xFF, and a write to any other offset changes no register.
- R3: A data read returns `rev_data_in` when control bit 5 is 1, and otherwise returns the last byte written to offset 0.
- R4: A control write whose bit 2 (init) is 0 sets the status register to 0xD8.
- R5: A control write with bits 2, 3 and 0 all set clears status bit 7. If control bit 0 was 0 before that write, `sink_valid` is 1 for exactly the next cycle and `sink_data` carries the data latch during that cycle. No other write emits a byte.
- R6: The strobe write of R5 sets an interrupt-pending flag when bit 4 of the newly written control value is 1. `irq` is a register that takes pending AND control bit 4, so it follows that state one cycle later.
- R7: A status read, while status bit 7 is 0 and control bit 0 is 0, advances the handshake. If bit 6 is 1 it is cleared; otherwise bits 6 and 7 are both set. Any other status read changes nothing.
- R8: The status read that sets bits 6 and 7 clears the interrupt-pending flag.
- R9: A control read returns the last byte written to offset 2. `port_strobe`, `port_autolf`, `port_init`, `port_select` and `port_dir` equal control bits 0, 1, 2, 3 and 5.
- R10: `bus_rdata` is combinational. It shows the register value from before the access, in the same cycle as the access.
- R11: A write to offset 1 has no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address before shift |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| rev_data_in | input | 8 | Input byte for reverse direction |
| port_strobe | output | 1 | Control bit 0 |
| port_autolf | output | 1 | Control bit 1 |
| port_init | output | 1 | Control bit 2 |
| port_select | output | 1 | Control bit 3 |
| port_dir | output | 1 | Control bit 5 |
| sink_valid | output | 1 | One-cycle byte emit pulse |
| sink_data | output | 8 | Emitted byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets repeated strobe writes with strobe already high. A design that looks at the new value instead of the previous one would emit the byte twice. It also polls status while strobe is still high, where a design that ignored the strobe qualifier would advance the handshake early. It checks that the interrupt clears only on the poll that completes the handshake, and that it is gated by the enable bit of the value just written. Other targets are init-low writes, direction flips on data reads, low address bits that must be discarded by the shift, and unused or status-register writes that must leave every register unchanged.

// File: rtl/printer_port_pkg.sv
package printer_port_pkg;

  localparam int REG_W = 8;

  // status bit positions
  localparam int ST_NBUSY  = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_NERR   = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_AFD  = 1;
  localparam int CT_STB  = 0;

  localparam logic [REG_W-1:0] STAT_RESET = 8'hD9;
  localparam logic [REG_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [REG_W-1:0] CTRL_RESET = 8'h0C;
  localparam logic [REG_W-1:0] RD_UNUSED  = 8'hFF;

  typedef struct packed {
    logic rd_data;
    logic rd_stat;
    logic rd_ctrl;
    logic rd_none;
    logic wr_data;
    logic wr_ctrl;
  } acc_t;

endpackage

// File: rtl/pport_decode.sv
module pport_decode
  import printer_port_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  localparam int OFF_W = ADDR_W - ADDR_SHIFT;

  logic [OFF_W-1:0] off;
  logic             is_data, is_stat, is_ctrl;

  assign off     = addr[ADDR_W-1:ADDR_SHIFT];
  assign is_data = (off == OFF_W'(0));
  assign is_stat = (off == OFF_W'(1));
  assign is_ctrl = (off == OFF_W'(2));

  always_comb begin
    acc         = '0;
    acc.rd_data = sel && !wr && is_data;
    acc.rd_stat = sel && !wr && is_stat;
    acc.rd_ctrl = sel && !wr && is_ctrl;
    acc.rd_none = sel && !wr && !(is_data || is_stat || is_ctrl);
    acc.wr_data = sel && wr && is_data;
    acc.wr_ctrl = sel && wr && is_ctrl;
  end
endmodule

// File: rtl/pport_latches.sv
module pport_latches
  import printer_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_t             acc,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] data_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic             strobe_evt,
  output logic             emit_q
);
  logic [REG_W-1:0] data_d, ctrl_d;
  logic             emit_d;

  assign strobe_evt = acc.wr_ctrl && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB];

  always_comb begin
    data_d = acc.wr_data ? wdata : data_q;
    ctrl_d = acc.wr_ctrl ? wdata : ctrl_q;
    // only a rising strobe pushes a byte out
    emit_d = strobe_evt && !ctrl_q[CT_STB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= CTRL_RESET;
      emit_q <= 1'b0;
    end else begin
      if (acc.wr_data) data_q <= data_d;
      if (acc.wr_ctrl) ctrl_q <= ctrl_d;
      emit_q <= emit_d;
    end
  end
endmodule

// File: rtl/pport_hshake.sv
module pport_hshake
  import printer_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_t             acc,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] ctrl_q,
  input  logic             strobe_evt,
  output logic [REG_W-1:0] stat_q,
  output logic             pend_q
);
  logic [REG_W-1:0] stat_d;
  logic             pend_d;
  logic             poll_step;

  assign poll_step = acc.rd_stat && !stat_q[ST_NBUSY] && !ctrl_q[CT_STB];

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    if (acc.wr_ctrl) begin
      if (!wdata[CT_INIT]) begin
        stat_d = STAT_INIT;
      end else if (strobe_evt) begin
        stat_d[ST_NBUSY] = 1'b0;
        if (wdata[CT_IEN]) pend_d = 1'b1;
      end
    end else if (poll_step) begin
      if (stat_q[ST_ACK]) begin
        stat_d[ST_ACK] = 1'b0;
      end else begin
        stat_d[ST_ACK]   = 1'b1;
        stat_d[ST_NBUSY] = 1'b1;
        pend_d           = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RESET;
      pend_q <= 1'b0;
    end else if (acc.wr_ctrl || poll_step) begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/printer_port_regs.sv
module printer_port_regs
  import printer_port_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        rev_data_in,
  output logic              port_strobe,
  output logic              port_autolf,
  output logic              port_init,
  output logic              port_select,
  output logic              port_dir,
  output logic              sink_valid,
  output logic [7:0]        sink_data,
  output logic              irq
);
  acc_t             acc;
  logic [REG_W-1:0] data_q, ctrl_q, stat_q;
  logic             strobe_evt, pend_q, irq_d, irq_q;

  pport_decode #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .acc(acc)
  );

  pport_latches u_lat (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(bus_wdata),
    .data_q(data_q), .ctrl_q(ctrl_q), .strobe_evt(strobe_evt), .emit_q(sink_valid)
  );

  pport_hshake u_hs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(bus_wdata), .ctrl_q(ctrl_q),
    .strobe_evt(strobe_evt), .stat_q(stat_q), .pend_q(pend_q)
  );

  assign irq_d = pend_q && ctrl_q[CT_IEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (acc.rd_data)      bus_rdata = ctrl_q[CT_DIR] ? rev_data_in : data_q;
    else if (acc.rd_stat) bus_rdata = stat_q;
    else if (acc.rd_ctrl) bus_rdata = ctrl_q;
    else if (acc.rd_none) bus_rdata = RD_UNUSED;
  end

  assign sink_data   = data_q;
  assign irq         = irq_q;
  assign port_strobe = ctrl_q[CT_STB];
  assign port_autolf = ctrl_q[CT_AFD];
  assign port_init   = ctrl_q[CT_INIT];
  assign port_select = ctrl_q[CT_SEL];
  assign port_dir    = ctrl_q[CT_DIR];
endmodule

// File: rtl/printer_port_regs_chk.sv
module printer_port_regs_chk #(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              sink_valid,
  input logic              irq,
  input logic [7:0]        stat_q,
  input logic [7:0]        ctrl_q,
  input logic              pend_q
);
  localparam int OFF_W = ADDR_W - ADDR_SHIFT;

  logic [OFF_W-1:0] off;
  logic             wr_ctrl, rd_stat, rd_bad;

  assign off     = bus_addr[ADDR_W-1:ADDR_SHIFT];
  assign wr_ctrl = bus_sel && bus_wr && (off == OFF_W'(2));
  assign rd_stat = bus_sel && !bus_wr && (off == OFF_W'(1));
  assign rd_bad  = bus_sel && !bus_wr && (off > OFF_W'(2));

  assert_unused_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> bus_rdata == 8'hFF);

  assert_init_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[2]) |=> stat_q == 8'hD8);

  assert_sink_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sink_valid |-> $past(wr_ctrl));

  assert_sink_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sink_valid |=> !sink_valid);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_q[4]));

  assert_ack_clears_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !stat_q[7] && !ctrl_q[0] && !stat_q[6]) |=> (!pend_q && stat_q[7] && stat_q[6]));
endmodule

bind printer_port_regs printer_port_regs_chk #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sink_valid(sink_valid), .irq(irq),
  .stat_q(stat_q), .ctrl_q(ctrl_q), .pend_q(pend_q)
);

// File: tb/printer_port_regs_tb_top.sv
module printer_port_regs_tb_top;
  localparam int AW = 8;
  localparam int SH = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata, rev_data_in, sink_data;
  logic          port_strobe, port_autolf, port_init, port_select, port_dir;
  logic          sink_valid, irq;

  always #2 clk = ~clk;

  printer_port_regs #(.ADDR_W(AW), .ADDR_SHIFT(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rev_data_in(rev_data_in),
    .port_strobe(port_strobe), .port_autolf(port_autolf), .port_init(port_init),
    .port_select(port_select), .port_dir(port_dir), .sink_valid(sink_valid),
    .sink_data(sink_data), .irq(irq)
  );

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // bench model of the registers
  logic [7:0] m_data, m_ctrl, m_stat;
  logic       m_pend;

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(int off);
    case (off)
      0:       return m_ctrl[5] ? rev_data_in : m_data;
      1:       return m_stat;
      2:       return m_ctrl;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string read_tag(int off);
    case (off)
      0:       return "R3 data read";
      1:       return "R7 status read";
      2:       return "R9 control read";
      default: return "R2 unused read";
    endcase
  endfunction

  // one bus cycle; the read value is checked in the access cycle (R10)
  task automatic cycle(bit sel, bit wr, int off, logic [7:0] wd);
    logic       exp_irq, emit;
    logic [7:0] byte_out;
    @(negedge clk);
    bus_sel     = sel;
    bus_wr      = wr;
    bus_addr    = AW'((off << SH) | $urandom_range(0, 3));
    bus_wdata   = wd;
    rev_data_in = 8'($urandom);
    #1;
    if (sel && !wr) check8(read_tag(off), bus_rdata, exp_read(off));
    exp_irq  = m_pend & m_ctrl[4];
    emit     = 1'b0;
    byte_out = m_data;
    if (sel && wr) begin
      if (off == 0) m_data = wd;
      else if (off == 2) begin
        if (!wd[2]) m_stat = 8'hD8;
        else if (wd[3] && wd[0]) begin
          m_stat[7] = 1'b0;
          if (!m_ctrl[0]) emit = 1'b1;
          if (wd[4]) m_pend = 1'b1;
        end
        m_ctrl = wd;
      end
    end else if (sel && off == 1 && !m_stat[7] && !m_ctrl[0]) begin
      if (m_stat[6]) m_stat[6] = 1'b0;
      else begin
        m_stat[6] = 1'b1;
        m_stat[7] = 1'b1;
        m_pend    = 1'b0; // R8
      end
    end
    @(posedge clk);
    #1;
    check8("R5 sink_valid", {7'd0, sink_valid}, {7'd0, emit});
    if (emit) check8("R5 sink_data", sink_data, byte_out);
    check8("R6 irq", {7'd0, irq}, {7'd0, exp_irq});
    check8("R9 pins", {3'd0, port_dir, port_select, port_init, port_autolf, port_strobe},
           {3'd0, m_ctrl[5], m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]});
  endtask

  task automatic idle();
    cycle(1'b0, 1'b0, 0, 8'h00);
  endtask

  function automatic logic [7:0] pick_ctrl();
    case ($urandom_range(0, 7))
      0: return 8'h0C;
      1: return 8'h0D;
      2: return 8'h1C;
      3: return 8'h1D;
      4: return 8'h08;
      5: return 8'h2C;
      6: return 8'h3D;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240607);
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; rev_data_in = '0;
    m_data = 8'h00; m_ctrl = 8'h0C; m_stat = 8'hD9; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    check8("R1 irq", {7'd0, irq}, 8'd0);
    check8("R1 sink_valid", {7'd0, sink_valid}, 8'd0);
    cycle(1, 0, 1, 0);             // R1 status 0xD9
    cycle(1, 0, 2, 0);             // R1 control 0x0C
    cycle(1, 0, 0, 0);             // R1 data 0x00
    // R11 write to status is ignored
    cycle(1, 1, 1, 8'h00);
    cycle(1, 0, 1, 0);
    // R2 unused write ignored, unused read 0xFF
    cycle(1, 1, 3, 8'h00);
    cycle(1, 0, 7, 0);
    cycle(1, 0, 2, 0);
    // R5/R6 strobe with interrupts enabled
    cycle(1, 1, 0, 8'hA5);
    cycle(1, 1, 2, 8'h1D);
    cycle(1, 1, 2, 8'h1D);         // R5 strobe held: no second byte
    cycle(1, 0, 1, 0);             // R7 strobe high: no step
    cycle(1, 1, 2, 8'h1C);
    cycle(1, 0, 1, 0);             // R7 ack cleared
    cycle(1, 0, 1, 0);             // R7/R8 ack+busy set, pending cleared
    idle(); idle();
    // R4 init low
    cycle(1, 1, 2, 8'h08);
    cycle(1, 0, 1, 0);
    // R3 reverse direction
    cycle(1, 1, 2, 8'h2C);
    cycle(1, 0, 0, 0);
    cycle(1, 1, 2, 8'h0C);
    cycle(1, 0, 0, 0);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      case ($urandom_range(0, 9))
        0, 1:    cycle(1, 1, 0, 8'($urandom));
        2, 3, 4: cycle(1, 1, 2, pick_ctrl());
        5, 6, 7: cycle(1, 0, 1, 0);
        8:       cycle(1, 0, ($urandom_range(0, 3) == 3) ? $urandom_range(3, 63) : 2 * $urandom_range(0, 1), 0);
        default: cycle($urandom_range(0, 1) == 1, 1, $urandom_range(1, 63) | 1, 8'($urandom));
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule